// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block connects an internal request port (16-bit address, 8-bit data) to a parallel external SRAM bus. The bus carries the low address byte and the data byte on one shared 8-bit pin group. An address-latch strobe marks when that group holds the low address. The high address byte has a dedicated pin group. Active-low read and write strobes complete each access. When the interface is enabled it takes over all of these pins and ignores whatever the general-purpose port logic asks for. When it is disabled, every pin carries the normal port value and direction.

An 8-bit control register holds the settings. Bit 7 enables the interface. Bits 6:4 hold the sector limit, which splits the address space into a lower and an upper sector. Bits 3:2 hold the wait-state code for the upper sector and bits 1:0 the code for the lower sector. Each access runs through a fixed sequence of named states. S_IDLE moves to S_PRE (only for wait code 3) or to S_ADDR when a request is accepted. S_PRE moves to S_ADDR. S_ADDR moves to S_HOLD. S_HOLD moves to S_STRB. S_STRB repeats until its wait count runs out, then moves to S_IDLE. An abort transition leads from every state to S_IDLE whenever the enable bit is low.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, busy and rdata_valid are 0, and every pad output and output enable equals the matching gpio input.
- R2: A write to the control register takes effect on the next clock edge and reads back unchanged. Bit 7 is enable, bits 6:4 are the sector limit L, bits 3:2 are the upper-sector wait code, and bits 1:0 are the lower-sector wait code.
- R3: While enable is 0, every pad output and output enable follows the gpio inputs, and request pulses are ignored (busy stays 0).
- R4: While enable is 1 and no access is running, the high-address output enables are all ones and the control output enables are 3'b111. ALE is 0, both strobes are 1, and the shared group output enable is zero. The gpio inputs have no effect.
- R5: For each access there is one S_ADDR cycle with ALE=1, the shared group driving addr[7:0] and the high group showing addr[15:8]. It is followed by one S_HOLD cycle with ALE=0 and addr[7:0] still driven. Only then does a strobe go low. ALE and the strobes are never active together.
- R6: An address belongs to the upper sector when addr >= L*8192. With L=0 the whole space is upper.
- R7: A strobe stays low for 1+n cycles, where n (0..3) is the wait code of the address's sector.
- R8: Wait code 3 adds one S_PRE cycle before S_ADDR. In that cycle ALE is 0, both strobes are 1, and the shared group is not driven.
- R9: busy is 1 from the cycle after acceptance through the last strobe cycle, which is 3+n cycles plus one when n=3. Requests presented while busy are ignored.
- R10: During a write, WR_n is low, RD_n is high, and the shared group drives the write data with output enable all ones.
- R11: During a read, RD_n is low, WR_n is high, and the shared group is not driven. rdata equals pad_ad_in sampled in the last strobe cycle. rdata_valid pulses for one cycle, in the first cycle that RD_n is high again.
- R12: Clearing enable during an access hands the pins back to gpio from the next cycle on, and the access ends by the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| rdata | output | 8 | Read data |
| rdata_valid | output | 1 | One-cycle read completion pulse |
| gpio_ad_out | input | 8 | Port value for the shared group |
| gpio_ad_oe | input | 8 | Port direction for the shared group |
| gpio_ah_out | input | 8 | Port value for the high group |
| gpio_ah_oe | input | 8 | Port direction for the high group |
| gpio_ctl_out | input | 3 | Port value for {ALE, WR_n, RD_n} pins |
| gpio_ctl_oe | input | 3 | Port direction for {ALE, WR_n, RD_n} pins |
| pad_ad_in | input | 8 | Shared group input value |
| pad_ad_out | output | 8 | Shared group output value |
| pad_ad_oe | output | 8 | Shared group output enable |
| pad_ah_out | output | 8 | High group output value |
| pad_ah_oe | output | 8 | High group output enable |
| pad_ale | output | 1 | Address latch enable pin |
| pad_wr_n | output | 1 | Write strobe pin |
| pad_rd_n | output | 1 | Read strobe pin |
| pad_ctl_oe | output | 3 | Output enable for {ALE, WR_n, RD_n} |

## Verification
The bench sweeps every sector limit against every pair of wait codes. For each setting it issues reads and writes at the address one below the boundary, at the boundary itself, and at the top of the space. A comparison off by one, or one that uses the wrong sector's field, lengthens or shortens the strobe and shows up at the boundary pair. A design that gives code 3 no setup cycle, or gives it to other codes, puts ALE in the wrong cycle. Holding the request line high for the whole access catches a controller that starts a second access early. An abort in the middle of an access checks that the pins return to the port values at once and that busy falls.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ADDR,
        S_HOLD,
        S_STRB
    } xb_state_t;

    localparam int CFG_W   = 8;
    localparam int EN_BIT  = 7;
    localparam int LIM_LSB = 4;
    localparam int LIM_W   = 3;
    localparam int UW_LSB  = 2;
    localparam int LW_LSB  = 0;
    localparam int WS_W    = 2;
    localparam logic [WS_W-1:0] WS_PRE_CODE = '1;
endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [AW-1:0]     lookup_addr,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              en,
    output logic [WS_W-1:0]   wait_code
);
    logic [LIM_W-1:0] lim;
    logic             upper;

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    assign en    = cfg_q[EN_BIT];
    assign lim   = cfg_q[LIM_LSB +: LIM_W];
    // top bits of the address compared with the limit == addr >= lim*step
    assign upper = (lookup_addr[AW-1 -: LIM_W] >= lim);
    assign wait_code = upper ? cfg_q[UW_LSB +: WS_W] : cfg_q[LW_LSB +: WS_W];

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_q == $past(cfg_wdata)); // R2
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [WS_W-1:0] wait_code,
    input  logic [DW-1:0]   pad_ad_in,
    output xb_state_t       st,
    output logic [AW-1:0]   addr_q,
    output logic [DW-1:0]   wdata_q,
    output logic            write_q,
    output logic [DW-1:0]   rdata,
    output logic            rdata_valid
);
    xb_state_t       nxt;
    logic [WS_W-1:0] cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: if (req_valid)
                        nxt = (wait_code == WS_PRE_CODE) ? S_PRE : S_ADDR;
            S_PRE:  nxt = S_ADDR;
            S_ADDR: nxt = S_HOLD;
            S_HOLD: nxt = S_STRB;
            S_STRB: if (cnt == '0) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (!en) nxt = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= S_IDLE;
            cnt         <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
            write_q     <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            st          <= nxt;
            rdata_valid <= 1'b0;
            if (st == S_IDLE && nxt != S_IDLE) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                cnt     <= wait_code;
            end
            if (st == S_STRB && cnt != '0)
                cnt <= cnt - 1'b1;
            if (st == S_STRB && nxt == S_IDLE && en && !write_q) begin
                rdata       <= pad_ad_in;
                rdata_valid <= 1'b1;
            end
        end
    end

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> st == S_IDLE); // R12
    AST_PRE_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PRE && en) |=> st == S_ADDR); // R8
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid,
    input  logic [DW-1:0] gpio_ad_out,
    input  logic [DW-1:0] gpio_ad_oe,
    input  logic [AW-DW-1:0] gpio_ah_out,
    input  logic [AW-DW-1:0] gpio_ah_oe,
    input  logic [2:0]    gpio_ctl_out,
    input  logic [2:0]    gpio_ctl_oe,
    input  logic [DW-1:0] pad_ad_in,
    output logic [DW-1:0] pad_ad_out,
    output logic [DW-1:0] pad_ad_oe,
    output logic [AW-DW-1:0] pad_ah_out,
    output logic [AW-DW-1:0] pad_ah_oe,
    output logic          pad_ale,
    output logic          pad_wr_n,
    output logic          pad_rd_n,
    output logic [2:0]    pad_ctl_oe
);
    localparam int HW = AW - DW;

    logic            en;
    logic [WS_W-1:0] wait_code;
    xb_state_t       st;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic            write_q;
    logic            ale_i, wr_i, rd_i, ad_drive;
    logic [DW-1:0]   ad_val;

    xbus_cfg #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .lookup_addr(req_addr), .cfg_q(cfg_rdata), .en(en), .wait_code(wait_code)
    );

    xbus_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .wait_code(wait_code), .pad_ad_in(pad_ad_in), .st(st),
        .addr_q(addr_q), .wdata_q(wdata_q), .write_q(write_q),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    assign busy = (st != S_IDLE);

    // output process: bus phase decode, then pin override
    always_comb begin
        ale_i    = 1'b0;
        wr_i     = 1'b0;
        rd_i     = 1'b0;
        ad_drive = 1'b0;
        ad_val   = addr_q[DW-1:0];
        unique case (st)
            S_IDLE, S_PRE: ;
            S_ADDR: begin ale_i = 1'b1; ad_drive = 1'b1; end
            S_HOLD: ad_drive = 1'b1;
            S_STRB: begin
                ad_val   = wdata_q;
                ad_drive = write_q;
                wr_i     = write_q;
                rd_i     = !write_q;
            end
            default: ;
        endcase

        if (en) begin
            pad_ad_out = ad_val;
            pad_ad_oe  = {DW{ad_drive}};
            pad_ah_out = addr_q[AW-1:DW];
            pad_ah_oe  = {HW{1'b1}};
            pad_ale    = ale_i;
            pad_wr_n   = !wr_i;
            pad_rd_n   = !rd_i;
            pad_ctl_oe = 3'b111;
        end else begin
            pad_ad_out = gpio_ad_out;
            pad_ad_oe  = gpio_ad_oe;
            pad_ah_out = gpio_ah_out;
            pad_ah_oe  = gpio_ah_oe;
            pad_ale    = gpio_ctl_out[2];
            pad_wr_n   = gpio_ctl_out[1];
            pad_rd_n   = gpio_ctl_out[0];
            pad_ctl_oe = gpio_ctl_oe;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $countones({pad_ale, !pad_wr_n, !pad_rd_n}) <= 1); // R5
    AST_ALE_BEFORE_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($fell(pad_rd_n) || $fell(pad_wr_n))) |-> !$past(pad_ale)); // R5
    AST_RDV_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (pad_rd_n && $past(!pad_rd_n))); // R11
    AST_HIGH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && busy && $past(busy)) |-> $stable(pad_ah_out)); // R9
endmodule

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy;
    logic [7:0]  rdata;
    logic        rdata_valid;
    logic [7:0]  gpio_ad_out = 8'h3C;
    logic [7:0]  gpio_ad_oe  = 8'h0F;
    logic [7:0]  gpio_ah_out = 8'hA5;
    logic [7:0]  gpio_ah_oe  = 8'hF0;
    logic [2:0]  gpio_ctl_out = 3'b010;
    logic [2:0]  gpio_ctl_oe  = 3'b101;
    logic [7:0]  pad_ad_in = '0;
    logic [7:0]  pad_ad_out, pad_ad_oe, pad_ah_out, pad_ah_oe;
    logic        pad_ale, pad_wr_n, pad_rd_n;
    logic [2:0]  pad_ctl_oe;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    xbus_ctrl dut (.*);

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // {busy, ale, wr_n, rd_n, ad_oe, ad_out, ah_oe, ah_out, ctl_oe}
    function automatic logic [63:0] obs(input bit with_ad);
        return {busy, pad_ale, pad_wr_n, pad_rd_n, pad_ad_oe,
                with_ad ? pad_ad_out : 8'h00, pad_ah_oe, pad_ah_out, pad_ctl_oe};
    endfunction

    function automatic logic [63:0] pads_gpio(input logic b);
        return {b, gpio_ctl_out, gpio_ad_oe, gpio_ad_out, gpio_ah_oe, gpio_ah_out, gpio_ctl_oe};
    endfunction

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d, input int n);
        logic [7:0] rin;
        rin = d ^ 8'hC3;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        pad_ad_in = rin;
        @(negedge clk);
        // keep requesting with junk values while busy: must be ignored (R9)
        req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        if (n == 3) begin
            check("R8 pre cycle", obs(0), {1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'hFF, a[15:8], 3'b111});
            @(negedge clk);
        end
        check("R5 addr cycle", obs(1), {1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, a[7:0], 8'hFF, a[15:8], 3'b111});
        @(negedge clk);
        check("R5 hold cycle", obs(1), {1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, a[7:0], 8'hFF, a[15:8], 3'b111});
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (wr)
                check("R7 R10 write strobe", obs(1), {1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, d, 8'hFF, a[15:8], 3'b111});
            else
                check("R7 R11 read strobe", obs(0), {1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'hFF, a[15:8], 3'b111});
            if (k == n) req_valid = 1'b0;
        end
        @(negedge clk);
        check("R9 busy ends", obs(0), {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'hFF, a[15:8], 3'b111});
        check("R11 read return", {rdata_valid, (wr ? 8'h00 : rdata)}, {!wr, (wr ? 8'h00 : rin)});
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cfg reset", cfg_rdata, 8'h00);
        check("R1 pads follow gpio", obs(1), pads_gpio(1'b0));
        check("R1 no read pulse", rdata_valid, 1'b0);

        // R3 disabled: request ignored, pads follow gpio
        req_valid = 1'b1; req_addr = 16'h1234;
        @(negedge clk);
        check("R3 request ignored", busy, 1'b0);
        gpio_ad_out = 8'h96; gpio_ctl_out = 3'b101; gpio_ah_oe = 8'h0F;
        #1;
        check("R3 pads follow gpio", obs(1), pads_gpio(1'b0));
        @(negedge clk);
        req_valid = 1'b0;

        // R2 read-back and R4 enabled idle override
        cfg_write(8'hA6);
        check("R2 read-back", cfg_rdata, 8'hA6);
        check("R4 idle override",
              {busy, pad_ale, pad_wr_n, pad_rd_n, pad_ad_oe, pad_ah_oe, pad_ctl_oe},
              {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 3'b111});

        // R6 R7 sweep over limit and both wait codes
        for (int lim = 0; lim < 8; lim++) begin
            for (int wu = 0; wu < 4; wu++) begin
                for (int wl = 0; wl < 4; wl++) begin
                    logic [7:0] c;
                    logic [15:0] b;
                    c = {1'b1, 3'(lim), 2'(wu), 2'(wl)};
                    cfg_write(c);
                    check("R2 cfg value", cfg_rdata, c);
                    b = 16'(lim * 8192);
                    if (lim > 0)
                        access((wu + wl) % 2 == 1, b - 16'd1, 8'(lim * 16 + wl), wl); // R6 lower
                    access((wu + wl) % 2 == 0, b, 8'(wu * 37 + lim), wu);            // R6 upper
                    access(lim[0], 16'hFFFF, 8'(wl * 11 + 5), wu);
                end
            end
        end

        // R12 abort during a long read
        cfg_write(8'b1000_1111);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0040;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 in strobe before abort", {busy, pad_rd_n}, {1'b1, 1'b0});
        cfg_we = 1'b1; cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R12 pins to gpio", obs(1), pads_gpio(1'b1));
        @(negedge clk);
        check("R12 access ended", {busy, rdata_valid}, 2'b00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule